// File: doc/BRIEF.md
# Minimum-Size Parallel Prefix Adder

This block adds two N-bit operands and a carry-in in pure combinational logic, producing an N-bit sum, a carry-out and a two's-complement overflow flag. N defaults to 16 and must be a power of two no smaller than 4. There is no clock inside the block; results settle within the same cycle as the inputs change, so the block is dropped into any datapath that needs a fast, compact adder.

Internally the work is split into three stages. The first turns each operand bit pair into a generate/propagate pair and absorbs the carry-in into bit 0. The second is a prefix network of merge nodes arranged as a reduction tree followed by a fill-in tree, which yields the group generate over bits [i:0] for every i. The third forms each sum bit from its propagate and the incoming group generate, and takes the carry-out and overflow from the two topmost group generates.

The prefix network is chosen for the smallest node count that still keeps depth logarithmic: 2N - 2 - log2(N) merge nodes spread over 2·log2(N) - 2 node levels (26 nodes over 6 levels at N = 16).

Top module: `bk_prefix_adder`

## Requirements
- R1: `sum_o` equals the low N bits of `a_i + b_i + c_in`, with all three taken as unsigned.
- R2: `c_out` equals bit N of the unsigned N+1-bit result of `a_i + b_i + c_in`.
- R3: `ovf_o` is 1 exactly when `a_i[N-1]` equals `b_i[N-1]` and `sum_o[N-1]` differs from them (signed overflow with the carry-in included).
- R4: The carry-in enters at bit 0: with both operands zero and `c_in` = 1 the sum is 1, and with one operand all ones, the other zero and `c_in` = 1 the carry crosses all N bits, giving a zero sum and `c_out` = 1.
- R5: The prefix network holds exactly 2N - 2 - log2(N) merge nodes (26 at N = 16).
- R6: The prefix network spans exactly 2·log2(N) - 2 node levels (6 at N = 16).
- R7: A bit that generates forces the carry out of that bit regardless of lower bits, and a bit where both operands are 0 blocks any lower carry from passing it.
- R8: Outputs are a pure function of the present inputs: a new input pattern is reflected at the outputs within the same clock cycle, with no state kept between patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First addend |
| b_i | input | N | Second addend |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| c_out | output | 1 | Carry out of bit N-1 |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The operands are tried with all-zero inputs, a lone carry-in, an all-ones operand plus carry-in that forces the carry across every bit, and sign-boundary pairs such as largest positive plus one and most negative plus most negative, which separate carry-out from signed overflow. Alternating bit patterns with and without carry-in distinguish a propagate-only chain from a generate, and a single generating bit below a blocking bit tests that carries start and stop where they should. A long run of pseudo-random operand pairs then exercises every prefix path, and the node and level counts of the network are compared against the closed-form expressions.

// File: rtl/bk_adder_pkg.sv
// Package: shared types and topology functions for the prefix adder.
// Assumes N is a power of two, N >= 4.
package bk_adder_pkg;

    // Generate/propagate pair carried through the prefix network.
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Associative merge of a higher span with the adjacent lower span.
    function automatic gp_t gp_merge(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // Number of node levels in the network for width n.
    function automatic int stage_count(int n);
        return 2 * $clog2(n) - 2;
    endfunction

    // Distance to the lower partner of bit i at level s (1-based), 0 = feed-through.
    // Levels 1..L carry the reduction tree; the fill-in tree for span 2^k
    // sits at level 2L-2-k, so its widest span shares level L with the root.
    function automatic int node_span(int n, int s, int i);
        int lg;
        int k;
        int sp;
        lg = $clog2(n);
        sp = 0;
        if (s >= 1 && s <= lg) begin
            k = s - 1;
            if (((i + 1) % (1 << (k + 1))) == 0)
                sp = 1 << k;
        end
        k = 2 * lg - 2 - s;
        if (k >= 0 && k <= lg - 2) begin
            if ((i + 1) >= 3 * (1 << k) &&
                (((i + 1) - 3 * (1 << k)) % (1 << (k + 1))) == 0)
                sp = 1 << k;
        end
        return sp;
    endfunction

    // Total merge nodes the network instantiates for width n.
    function automatic int count_nodes(int n);
        int total;
        total = 0;
        for (int s = 1; s <= stage_count(n); s++)
            for (int i = 0; i < n; i++)
                if (node_span(n, s, i) > 0)
                    total++;
        return total;
    endfunction

endpackage

// File: rtl/bk_gp_pregen.sv
// Module: per-bit generate/propagate formation with carry-in folded into bit 0.
// Assumes: purely combinational, N >= 1.
module bk_gp_pregen #(
    parameter int N = 16
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         c_in,
    output logic [N-1:0] g_bit,
    output logic [N-1:0] p_bit
);

    logic [N-1:0] g_raw;

    // Raw generate and propagate for every bit position.
    always_comb begin
        g_raw = a_i & b_i;
        p_bit = a_i ^ b_i;
    end

    // Bit 0 also generates when it propagates an incoming carry.
    always_comb begin
        g_bit    = g_raw;
        g_bit[0] = g_raw[0] | (p_bit[0] & c_in);
    end

endmodule

// File: rtl/bk_gp_node.sv
// Module: one merge node of the prefix network.
// Assumes: hi covers the span directly above lo.
module bk_gp_node
    import bk_adder_pkg::*;
(
    input  gp_t hi,
    input  gp_t lo,
    output gp_t res
);

    // Combine the two adjacent spans.
    always_comb res = gp_merge(hi, lo);

endmodule

// File: rtl/bk_prefix_net.sv
// Module: minimum-size logarithmic prefix network (reduction + fill-in trees).
// Assumes: N is a power of two, N >= 4; outputs are group values over [i:0].
module bk_prefix_net
    import bk_adder_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] g_bit,
    input  logic [N-1:0] p_bit,
    output logic [N-1:0] g_grp
);

    localparam int NSTG = stage_count(N);

    for (genvar s = 0; s <= NSTG; s++) begin : g_stage
        logic [N-1:0] gv;
        logic [N-1:0] pv;
        if (s == 0) begin : g_seed
            assign gv = g_bit;
            assign pv = p_bit;
        end else begin : g_level
            for (genvar i = 0; i < N; i++) begin : g_col
                localparam int SP = node_span(N, s, i);
                if (SP > 0) begin : g_node
                    gp_t hi_gp;
                    gp_t lo_gp;
                    gp_t out_gp;
                    assign hi_gp = '{g: g_stage[s-1].gv[i],    p: g_stage[s-1].pv[i]};
                    assign lo_gp = '{g: g_stage[s-1].gv[i-SP], p: g_stage[s-1].pv[i-SP]};
                    bk_gp_node u_node (
                        .hi  (hi_gp),
                        .lo  (lo_gp),
                        .res (out_gp)
                    );
                    assign gv[i] = out_gp.g;
                    assign pv[i] = out_gp.p;
                end else begin : g_feed
                    assign gv[i] = g_stage[s-1].gv[i];
                    assign pv[i] = g_stage[s-1].pv[i];
                end
            end
        end
    end

    logic [N-1:0] p_grp;

    // Expose the final level of the network.
    always_comb begin
        g_grp = g_stage[NSTG].gv;
        p_grp = g_stage[NSTG].pv;
    end

    // Per-bit carry start/stop and full-propagate relations on the network output.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (g_bit[i])
                AST_GEN_FORCES: assert (g_grp[i]) else $error("generate not forced at %0d", i); // R7
            if (!g_bit[i] && !p_bit[i])
                AST_KILL_BLOCKS: assert (!g_grp[i]) else $error("kill not honoured at %0d", i); // R7
            if (p_grp[i])
                AST_PROP_CHAIN: assert (g_grp[i] == g_bit[0]) else $error("propagate chain mismatch at %0d", i); // R7
        end
    end

endmodule

// File: rtl/bk_sum_post.sv
// Module: sum, carry-out and overflow from per-bit propagates and group generates.
// Assumes: g_grp[i] is the carry into bit i+1, carry-in already folded upstream.
module bk_sum_post #(
    parameter int N = 16
) (
    input  logic [N-1:0] p_bit,
    input  logic [N-1:0] g_grp,
    input  logic         c_in,
    output logic [N-1:0] sum_o,
    output logic         c_out,
    output logic         ovf_o
);

    logic [N:0] carry;

    // Carry vector: carry-in at the bottom, group generates above.
    always_comb carry = {g_grp, c_in};

    // Sum bits and flags from the carry vector.
    always_comb begin
        sum_o = p_bit ^ carry[N-1:0];
        c_out = carry[N];
        ovf_o = carry[N] ^ carry[N-1];
    end

endmodule

// File: rtl/bk_prefix_adder.sv
// Module: top of the N-bit minimum-size parallel prefix adder.
// Assumes: N is a power of two, N >= 4; fully combinational.
module bk_prefix_adder #(
    parameter int N = 16
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         c_in,
    output logic [N-1:0] sum_o,
    output logic         c_out,
    output logic         ovf_o
);

    logic [N-1:0] g_bit;
    logic [N-1:0] p_bit;
    logic [N-1:0] g_grp;

    bk_gp_pregen #(.N(N)) u_pregen (
        .a_i   (a_i),
        .b_i   (b_i),
        .c_in  (c_in),
        .g_bit (g_bit),
        .p_bit (p_bit)
    );

    bk_prefix_net #(.N(N)) u_net (
        .g_bit (g_bit),
        .p_bit (p_bit),
        .g_grp (g_grp)
    );

    bk_sum_post #(.N(N)) u_post (
        .p_bit (p_bit),
        .g_grp (g_grp),
        .c_in  (c_in),
        .sum_o (sum_o),
        .c_out (c_out),
        .ovf_o (ovf_o)
    );

    // Arithmetic cross-check of the whole datapath and the sign-based overflow rule.
    always_comb begin
        AST_SUM_MATCH: assert ({c_out, sum_o} ==
            ((N+1)'(a_i) + (N+1)'(b_i) + (N+1)'(c_in))) else $error("sum mismatch"); // R1
        AST_OVF_SIGN: assert (ovf_o == ((a_i[N-1] == b_i[N-1]) &&
            (sum_o[N-1] != a_i[N-1]))) else $error("overflow rule broken"); // R3
    end

endmodule

// File: tb/bk_prefix_adder_tb.sv
module bk_prefix_adder_tb;
    import bk_adder_pkg::*;

    localparam int N = 16;

    typedef struct {
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic         ci;
        logic [N-1:0] sum;
        logic         co;
        logic         ov;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] a_i = '0;
    logic [N-1:0] b_i = '0;
    logic         c_in = 1'b0;
    logic [N-1:0] sum_o;
    logic         c_out;
    logic         ovf_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  drv_done = 1'b0;
    item_t exp_q[$];

    always #5 clk = ~clk;

    bk_prefix_adder #(.N(N)) u_dut (
        .a_i   (a_i),
        .b_i   (b_i),
        .c_in  (c_in),
        .sum_o (sum_o),
        .c_out (c_out),
        .ovf_o (ovf_o)
    );

    task automatic check(string tag, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
        end
    endtask

    // Driver: apply operands at a rising edge and queue the expected result.
    task automatic drive(logic [N-1:0] a, logic [N-1:0] b, logic ci, string tag);
        item_t it;
        logic [N:0] full;
        @(posedge clk);
        a_i  = a;
        b_i  = b;
        c_in = ci;
        full = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, ci};
        it.a = a; it.b = b; it.ci = ci;
        it.sum = full[N-1:0];
        it.co  = full[N];
        it.ov  = (a[N-1] == b[N-1]) && (full[N-1] != a[N-1]);
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compare at the falling edge of the same cycle (R8).
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                item_t e;
                e = exp_q.pop_front();
                check({e.tag, " R1 sum"}, int'(sum_o), int'(e.sum));
                check({e.tag, " R2 cout"}, int'(c_out), int'(e.co));
                check({e.tag, " R3 ovf"}, int'(ovf_o), int'(e.ov));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: zero inputs give zero outputs.
        @(negedge clk);
        check("reset R1 sum", int'(sum_o), 0);
        check("reset R2 cout", int'(c_out), 0);
        check("reset R3 ovf", int'(ovf_o), 0);

        // R5 and R6: topology counts against closed forms.
        check("R5 node count", count_nodes(N), 2 * N - 2 - $clog2(N));
        check("R5 node count 16", count_nodes(16), 26);
        check("R6 level count", stage_count(N), 2 * $clog2(N) - 2);
        check("R6 level count 16", stage_count(16), 6);
        check("R5 node count 8", count_nodes(8), 11);

        drive(16'h0000, 16'h0000, 1'b1, "R4 lone cin");
        drive(16'hFFFF, 16'h0000, 1'b1, "R4 full carry");
        drive(16'h0000, 16'hFFFF, 1'b1, "R4 full carry swap");
        drive(16'h7FFF, 16'h0001, 1'b0, "R3 pos overflow");
        drive(16'h8000, 16'h8000, 1'b0, "R3 neg overflow");
        drive(16'h8000, 16'hFFFF, 1'b0, "R3 neg overflow small");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R2 all ones");
        drive(16'h7FFF, 16'h0000, 1'b1, "R3 cin overflow");
        drive(16'hAAAA, 16'h5555, 1'b0, "R7 propagate only");
        drive(16'hAAAA, 16'h5555, 1'b1, "R7 propagate with cin");
        drive(16'h0080, 16'h0080, 1'b0, "R7 generate bit7");
        drive(16'h00FF, 16'h0001, 1'b0, "R7 ripple to bit8");
        drive(16'h0F0F, 16'h0001, 1'b1, "R7 kill at bit4");
        drive(16'h0000, 16'h0000, 1'b0, "R8 back to zero");
        for (int k = 0; k < 300; k++)
            drive(N'($urandom), N'($urandom), 1'($urandom), "R1 random");
        drv_done = 1'b1;
        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule